// File: doc/BRIEF.md
# Indirect Packet Buffer Access Port

This block gives a host processor access to an on-chip packet buffer through a small byte-wide register port. The host places an 8-bit index on `host_idx` and raises `host_rd` or `host_wr` for one cycle per access. The buffer is never addressed directly. It is reached through two 16-bit pointers, one for reads and one for writes. Certain data indices move a byte between the port and the buffer. Some of them then step their pointer, and others leave it where it is, which allows a look-ahead read and an in-place overwrite.

The same index space also holds both pointers as byte pairs, a 16-bit transmit length pair and an interrupt status/mask pair. Status bits are latched from event pulses and cleared by writing 1. The `irq` output stays high while any latched status bit is also enabled in the mask.

Read data comes from a registered source selector, a three-state machine. `SRC_NONE` is the reset state and drives zero. `SRC_BUF` drives the buffer RAM output. `SRC_REG` drives a captured register value. On every read strobe the machine takes transition T_BUF (index F0h/F1h/F2h, into `SRC_BUF`) or transition T_REG (any other index, into `SRC_REG`). With no read strobe it takes T_HOLD and stays in its state.

Top module: `buf_port_top`

## Requirements
- R1: After reset both pointers, the status register and the mask read 00h, `irq` is 0 and `host_rdata` is 00h.
- R2: A read of index F0h returns the buffer byte at the read pointer and leaves the read pointer unchanged.
- R3: A read of index F1h or F2h returns the buffer byte at the read pointer and advances the read pointer by one. Back-to-back strobes read consecutive addresses with no idle cycle.
- R4: A write to index F6h stores `host_wdata` at the write pointer and leaves the write pointer unchanged.
- R5: A write to index F8h stores `host_wdata` at the write pointer and advances the write pointer by one. Back-to-back strobes fill consecutive addresses.
- R6: The read pointer is readable and writable as low byte F4h and high byte F5h. The write pointer uses FAh (low) and FBh (high).
- R7: A pointer that steps from the last buffer address (2^BUF_AW-1, 03FFh by default) goes to 0000h.
- R8: The transmit length is readable and writable as low byte FCh and high byte FDh.
- R9: Index FEh holds one status bit per event input in bits NUM_IRQ-1:0, where bit i is set by a pulse on `evt_in[i]`. Writing 1 to a bit clears it and writing 0 leaves it alone. An event in the same cycle as its clear leaves the bit set. Bits above NUM_IRQ-1 read 0.
- R10: Index FFh holds the mask in bits NUM_IRQ-1:0, and upper bits written there read back 0. `irq` is 1 exactly when some status bit and its mask bit are both 1, and it follows a change one cycle after the strobe or event.
- R11: `host_rdata` shows read data in the cycle after the read strobe. It keeps that value, across writes and idle cycles, until the next read strobe.
- R12: When `host_rd` and `host_wr` are both high, the write is dropped and only the read is performed. Reads of indices without a register, and of F6h/F8h, return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_idx | input | 8 | Register index of the access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| evt_in | input | NUM_IRQ | Interrupt event pulses, one per status bit |
| irq | output | 1 | Interrupt request, any enabled status bit set |

## Verification
A pointer that steps wrongly or fails to step shows up on the next data read as a wrong byte. It appears one cycle after that read's strobe, and reading back F4h/F5h or FAh/FBh exposes it directly. A wrong read-source state shows up on `host_rdata` in the cycle after a strobe, or as data changing during idle cycles. A status bit that sets or clears wrongly shows on `irq` one cycle after the event or write, and on the FEh readback.

// File: rtl/buf_port_pkg.sv
package buf_port_pkg;
    // Index map of the host port
    localparam logic [7:0] IX_PEEK   = 8'hF0;
    localparam logic [7:0] IX_POP_A  = 8'hF1;
    localparam logic [7:0] IX_POP_B  = 8'hF2;
    localparam logic [7:0] IX_RP_LO  = 8'hF4;
    localparam logic [7:0] IX_RP_HI  = 8'hF5;
    localparam logic [7:0] IX_PUT    = 8'hF6;
    localparam logic [7:0] IX_PUSH   = 8'hF8;
    localparam logic [7:0] IX_WP_LO  = 8'hFA;
    localparam logic [7:0] IX_WP_HI  = 8'hFB;
    localparam logic [7:0] IX_TXL_LO = 8'hFC;
    localparam logic [7:0] IX_TXL_HI = 8'hFD;
    localparam logic [7:0] IX_STAT   = 8'hFE;
    localparam logic [7:0] IX_MASK   = 8'hFF;

    // Source of host_rdata
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_BUF  = 2'd1,
        SRC_REG  = 2'd2
    } rsrc_e;
endpackage

// File: rtl/buf_ram.sv
module buf_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            q <= mem[raddr];
        end
    end

    assign rdata = q;
endmodule

// File: rtl/buf_ptr.sv
module buf_ptr #(
    parameter int PW = 16,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [7:0]    din,
    input  logic          step,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'((64'd1 << AW) - 64'd1);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_inc;

    always_comb begin
        if (ptr_q >= LAST) begin
            ptr_inc = '0;
        end else begin
            ptr_inc = ptr_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (step) begin
            ptr_q <= ptr_inc;
        end else if (ld_lo) begin
            ptr_q[7:0] <= din;
        end else if (ld_hi) begin
            ptr_q[PW-1:8] <= din[PW-9:0];
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/buf_irq.sv
module buf_irq #(
    parameter int NI = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NI-1:0] evt,
    input  logic          clr_we,
    input  logic          mask_we,
    input  logic [7:0]    din,
    output logic [NI-1:0] stat,
    output logic [NI-1:0] mask,
    output logic          irq
);
    logic [NI-1:0] stat_q;
    logic [NI-1:0] mask_q;
    logic [NI-1:0] clr_bits;

    assign clr_bits = clr_we ? din[NI-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_bits) | evt;
            if (mask_we) begin
                mask_q <= din[NI-1:0];
            end
        end
    end

    assign stat = stat_q;
    assign mask = mask_q;
    assign irq  = |(stat_q & mask_q);
endmodule

// File: rtl/buf_port_top.sv
module buf_port_top
    import buf_port_pkg::*;
#(
    parameter int BUF_AW  = 10,
    parameter int PTR_W   = 16,
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         host_idx,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic [NUM_IRQ-1:0] evt_in,
    output logic               irq
);
    localparam int HI_W = PTR_W - 8;

    // Access decode
    logic is_buf_rd;
    logic rd_step;
    logic wr_ok;
    logic wr_mem;
    logic wr_step;

    assign is_buf_rd = (host_idx == IX_PEEK) || (host_idx == IX_POP_A) ||
                       (host_idx == IX_POP_B);
    assign rd_step   = host_rd && ((host_idx == IX_POP_A) || (host_idx == IX_POP_B));
    assign wr_ok     = host_wr && !host_rd;
    assign wr_mem    = wr_ok && ((host_idx == IX_PUT) || (host_idx == IX_PUSH));
    assign wr_step   = wr_ok && (host_idx == IX_PUSH);

    // Pointers
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;

    buf_ptr #(.PW(PTR_W), .AW(BUF_AW)) u_rptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (wr_ok && (host_idx == IX_RP_LO)),
        .ld_hi (wr_ok && (host_idx == IX_RP_HI)),
        .din   (host_wdata),
        .step  (rd_step),
        .ptr   (rd_ptr)
    );

    buf_ptr #(.PW(PTR_W), .AW(BUF_AW)) u_wptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (wr_ok && (host_idx == IX_WP_LO)),
        .ld_hi (wr_ok && (host_idx == IX_WP_HI)),
        .din   (host_wdata),
        .step  (wr_step),
        .ptr   (wr_ptr)
    );

    // Packet buffer
    logic [7:0] ram_q;

    buf_ram #(.AW(BUF_AW), .DW(8)) u_ram (
        .clk   (clk),
        .we    (wr_mem),
        .waddr (wr_ptr[BUF_AW-1:0]),
        .wdata (host_wdata),
        .re    (host_rd && is_buf_rd),
        .raddr (rd_ptr[BUF_AW-1:0]),
        .rdata (ram_q)
    );

    // Interrupt status and mask
    logic [NUM_IRQ-1:0] irq_stat;
    logic [NUM_IRQ-1:0] irq_mask;

    buf_irq #(.NI(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_in),
        .clr_we  (wr_ok && (host_idx == IX_STAT)),
        .mask_we (wr_ok && (host_idx == IX_MASK)),
        .din     (host_wdata),
        .stat    (irq_stat),
        .mask    (irq_mask),
        .irq     (irq)
    );

    // Transmit length, no reset value
    logic [15:0] tx_len_q;

    always_ff @(posedge clk) begin
        if (wr_ok && (host_idx == IX_TXL_LO)) begin
            tx_len_q[7:0] <= host_wdata;
        end
        if (wr_ok && (host_idx == IX_TXL_HI)) begin
            tx_len_q[15:8] <= host_wdata;
        end
    end

    // Register readback mux
    logic [7:0] reg_mux;
    logic [7:0] reg_hold_q;

    always_comb begin
        unique case (host_idx)
            IX_RP_LO:  reg_mux = rd_ptr[7:0];
            IX_RP_HI:  reg_mux = 8'(rd_ptr[PTR_W-1:PTR_W-HI_W]);
            IX_WP_LO:  reg_mux = wr_ptr[7:0];
            IX_WP_HI:  reg_mux = 8'(wr_ptr[PTR_W-1:PTR_W-HI_W]);
            IX_TXL_LO: reg_mux = tx_len_q[7:0];
            IX_TXL_HI: reg_mux = tx_len_q[15:8];
            IX_STAT:   reg_mux = 8'(irq_stat);
            IX_MASK:   reg_mux = 8'(irq_mask);
            default:   reg_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_hold_q <= 8'h00;
        end else if (host_rd && !is_buf_rd) begin
            reg_hold_q <= reg_mux;
        end
    end

    // Read-source state machine
    rsrc_e src_q;
    rsrc_e src_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= SRC_NONE;
        end else begin
            src_q <= src_d;
        end
    end

    always_comb begin
        src_d = src_q;
        if (host_rd) begin
            if (is_buf_rd) begin
                src_d = SRC_BUF;
            end else begin
                src_d = SRC_REG;
            end
        end
    end

    always_comb begin
        unique case (src_q)
            SRC_NONE: host_rdata = 8'h00;
            SRC_BUF:  host_rdata = ram_q;
            SRC_REG:  host_rdata = reg_hold_q;
            default:  host_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/buf_port_chk.sv
module buf_port_chk
    import buf_port_pkg::*;
#(
    parameter int BUF_AW  = 10,
    parameter int PTR_W   = 16,
    parameter int NUM_IRQ = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         host_idx,
    input logic               host_rd,
    input logic               host_wr,
    input logic [NUM_IRQ-1:0] evt_in,
    input logic               irq,
    input logic [PTR_W-1:0]   rd_ptr,
    input logic [PTR_W-1:0]   wr_ptr,
    input logic [NUM_IRQ-1:0] irq_stat,
    input logic [NUM_IRQ-1:0] irq_mask
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'((64'd1 << BUF_AW) - 64'd1);

    // R2: a look-ahead read keeps the read pointer
    a_r2_peek_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_idx == IX_PEEK) |=> $stable(rd_ptr));

    // R3, R7: a consuming read steps the read pointer, wrapping at the top
    a_r3_pop_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (host_idx == IX_POP_A || host_idx == IX_POP_B)) |=>
        (rd_ptr == (($past(rd_ptr) >= LAST) ? '0 : $past(rd_ptr) + PTR_W'(1))));

    // R4: an in-place write keeps the write pointer
    a_r4_put_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rd && host_idx == IX_PUT) |=> $stable(wr_ptr));

    // R5, R7: a stepping write advances the write pointer, wrapping at the top
    a_r5_push_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rd && host_idx == IX_PUSH) |=>
        (wr_ptr == (($past(wr_ptr) >= LAST) ? '0 : $past(wr_ptr) + PTR_W'(1))));

    // R9: every pulsed event is latched in the next cycle
    a_r9_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_in) |=> ((irq_stat & $past(evt_in)) == $past(evt_in)));

    // R10: no request while the mask is all zero
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);

    // R12: a write that collides with a read does not move the write pointer
    a_r12_collision_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_wr) |=> $stable(wr_ptr));
endmodule

bind buf_port_top buf_port_chk #(
    .BUF_AW  (BUF_AW),
    .PTR_W   (PTR_W),
    .NUM_IRQ (NUM_IRQ)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_idx (host_idx),
    .host_rd  (host_rd),
    .host_wr  (host_wr),
    .evt_in   (evt_in),
    .irq      (irq),
    .rd_ptr   (rd_ptr),
    .wr_ptr   (wr_ptr),
    .irq_stat (irq_stat),
    .irq_mask (irq_mask)
);

// File: tb/buf_port_top_test.sv
module buf_port_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_idx = 8'h00;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [3:0] evt_in = 4'h0;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen = 1'b0;

    always #10 clk = ~clk;

    buf_port_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_idx   (host_idx),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .evt_in     (evt_in),
        .irq        (irq)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: one result per read strobe, valid after the following edge
    always @(posedge clk) rd_seen <= rst_n && host_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", host_rdata, 8'hxx);
            end else begin
                chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    // Driver: one access per cycle, changed at the falling edge
    task automatic cyc(logic r, logic w, logic [7:0] i, logic [7:0] d);
        host_rd    = r;
        host_wr    = w;
        host_idx   = i;
        host_wdata = d;
        @(negedge clk);
    endtask

    task automatic rdx(logic [7:0] i, logic [7:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        cyc(1'b1, 1'b0, i, 8'h00);
    endtask

    task automatic wrx(logic [7:0] i, logic [7:0] d);
        cyc(1'b0, 1'b1, i, d);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 8'h00, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        chk("R1 rdata", host_rdata, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        @(negedge clk);
        rdx(8'hF4, 8'h00, "R1 rptr lo");
        rdx(8'hF5, 8'h00, "R1 rptr hi");
        rdx(8'hFA, 8'h00, "R1 wptr lo");
        rdx(8'hFB, 8'h00, "R1 wptr hi");
        rdx(8'hFE, 8'h00, "R1 status");
        rdx(8'hFF, 8'h00, "R1 mask");

        // R5: back-to-back stepping writes
        wrx(8'hF8, 8'h11);
        wrx(8'hF8, 8'h22);
        wrx(8'hF8, 8'h33);
        wrx(8'hF8, 8'h44);
        rdx(8'hFA, 8'h04, "R5 wptr after burst");
        // R4: in-place write, then overwrite with a stepping write
        wrx(8'hF6, 8'h55);
        rdx(8'hFA, 8'h04, "R4 wptr kept");
        wrx(8'hF8, 8'h66);
        rdx(8'hFA, 8'h05, "R5 wptr stepped");

        // R2: look-ahead reads
        rdx(8'hF0, 8'h11, "R2 peek first");
        rdx(8'hF0, 8'h11, "R2 peek again");
        rdx(8'hF4, 8'h00, "R2 rptr kept");

        // R3: back-to-back consuming reads via both indices
        rdx(8'hF1, 8'h11, "R3 pop 0");
        rdx(8'hF2, 8'h22, "R3 pop 1");
        rdx(8'hF1, 8'h33, "R3 pop 2");
        rdx(8'hF2, 8'h44, "R3 pop 3");
        rdx(8'hF4, 8'h04, "R3 rptr after pops");
        rdx(8'hF0, 8'h66, "R4 overwritten byte");

        // R6: pointer byte registers
        wrx(8'hF4, 8'h02);
        wrx(8'hF5, 8'h00);
        rdx(8'hF0, 8'h33, "R6 peek at loaded rptr");
        rdx(8'hF4, 8'h02, "R6 rptr lo");
        wrx(8'hF5, 8'h12);
        rdx(8'hF5, 8'h12, "R6 rptr hi");
        wrx(8'hFB, 8'h34);
        rdx(8'hFB, 8'h34, "R6 wptr hi");

        // R7: wrap of both pointers at 03FFh
        wrx(8'hFA, 8'hFF);
        wrx(8'hFB, 8'h03);
        wrx(8'hF8, 8'hA5);
        wrx(8'hF8, 8'h5A);
        rdx(8'hFA, 8'h01, "R7 wptr lo wrapped");
        rdx(8'hFB, 8'h00, "R7 wptr hi wrapped");
        wrx(8'hF4, 8'hFF);
        wrx(8'hF5, 8'h03);
        rdx(8'hF1, 8'hA5, "R7 pop top");
        rdx(8'hF1, 8'h5A, "R7 pop after wrap");
        rdx(8'hF4, 8'h01, "R7 rptr lo wrapped");
        rdx(8'hF5, 8'h00, "R7 rptr hi wrapped");

        // R8: transmit length
        wrx(8'hFC, 8'h34);
        wrx(8'hFD, 8'h12);
        rdx(8'hFC, 8'h34, "R8 len lo");
        rdx(8'hFD, 8'h12, "R8 len hi");

        // R9, R10: status, mask and request
        evt_in = 4'b0010;
        idle(1);
        evt_in = 4'b0000;
        #1 chk("R10 irq masked", {7'b0, irq}, 8'h00);
        rdx(8'hFE, 8'h02, "R9 status set");
        wrx(8'hFF, 8'hF2);
        #1 chk("R10 irq enabled", {7'b0, irq}, 8'h01);
        rdx(8'hFF, 8'h02, "R10 mask upper bits");
        wrx(8'hFE, 8'h01);
        rdx(8'hFE, 8'h02, "R9 clear of other bit");
        #1 chk("R10 irq still set", {7'b0, irq}, 8'h01);
        wrx(8'hFE, 8'h02);
        #1 chk("R10 irq cleared", {7'b0, irq}, 8'h00);
        rdx(8'hFE, 8'h00, "R9 status cleared");
        evt_in = 4'b0100;
        wrx(8'hFE, 8'h04);
        evt_in = 4'b0000;
        rdx(8'hFE, 8'h04, "R9 set beats clear");
        #1 chk("R10 irq gated by mask", {7'b0, irq}, 8'h00);

        // R11: read data held across writes and idle cycles
        rdx(8'hF0, 8'h22, "R11 peek");
        idle(1);
        wrx(8'hF8, 8'h77);
        wrx(8'hFC, 8'h99);
        idle(2);
        #1 chk("R11 rdata held", host_rdata, 8'h22);
        rdx(8'hF0, 8'h77, "R11 new data after write");

        // R12: collision drops the write; unused and write-only indices read 00h
        exp_q.push_back(8'h00);
        tag_q.push_back("R12 collision read");
        cyc(1'b1, 1'b1, 8'hF8, 8'h99);
        rdx(8'hFA, 8'h02, "R12 wptr not stepped");
        wrx(8'hF4, 8'h02);
        rdx(8'hF0, 8'h33, "R12 buffer not written");
        rdx(8'h10, 8'h00, "R12 unused index");
        rdx(8'hF6, 8'h00, "R12 write-only index");

        idle(3);
        chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule